// File: doc/BRIEF.md
# Hot-Plug Change Interrupt Detector

This block watches an asynchronous hot-plug detect input and reports any change of its state. The input is brought into the clock domain through a chain of synchronizer flops. Its synchronized level is available as a status bit at all times, whatever the interrupt state. A rising or a falling transition sets a sticky change flag. That flag pulls two active-low interrupt outputs low, and each output is gated on its own terms.

The termination-detect output signals only while the digital video output is selected. The general-purpose pin signals only when both its interrupt enable and its pin output enable are set. Each output is modelled as an active-low level paired with a drive enable. Software acknowledges a change by setting a clear control bit high and then returning it low. While the bit is high, the flag stays cleared and transitions are not recorded.

Top module: `hpd_change_irq`

## Requirements
- R1: `hpdLevel` equals the value `hpdAsync` held two clock edges earlier. It follows the input whether or not a change is pending.
- R2: A rising transition of the synchronized input sets `changePending` on the next clock edge, three edges after `hpdAsync` rose.
- R3: A falling transition of the synchronized input sets `changePending` with the same three-edge timing as a rising one.
- R4: The termination-detect output is active (`tdetN`=0, `tdetDrive`=1) exactly when `changePending`=1 and `digOutSel`=1. Otherwise it is released (`tdetN`=1, `tdetDrive`=0).
- R5: The general-purpose interrupt output is active (`gpioN`=0, `gpioDrive`=1) only when `changePending`, `irqEnable` and `pinOutEnable` are all 1. Otherwise it is released (`gpioN`=1, `gpioDrive`=0).
- R6: While `clearCtl`=1, `changePending` is 0 from the next clock edge on. Transitions that occur while `clearCtl`=1 are never reported. Detection resumes once `clearCtl` returns to 0.
- R7: Once set, `changePending` stays 1 until `clearCtl` or `rst` is applied. Further transitions keep it at 1.
- R8: Synchronous active-high `rst` clears `changePending` and releases both outputs. After `rst` is released, no change is reported for an input that holds a steady level through the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hpdAsync | input | 1 | Asynchronous hot-plug detect input |
| digOutSel | input | 1 | Digital video output selected |
| irqEnable | input | 1 | Interrupt enable for the general-purpose pin |
| pinOutEnable | input | 1 | Output enable of the general-purpose pin |
| clearCtl | input | 1 | Clear control bit; set high, then low, to acknowledge |
| hpdLevel | output | 1 | Synchronized live level of the input |
| changePending | output | 1 | Sticky change flag |
| tdetN | output | 1 | Termination-detect output, active low |
| tdetDrive | output | 1 | Drive enable of the termination-detect output |
| gpioN | output | 1 | General-purpose interrupt output, active low |
| gpioDrive | output | 1 | Drive enable of the general-purpose output |

## Verification
The assertions check the output gating on every cycle. They check that the flag is cleared one edge after `clearCtl` or `rst`, that it never falls on its own, and that it never rises while a clear is in progress. Other behaviours can only be shown by the bench's scenarios. These are the exact three-edge latency from an input transition to the flag, that both transition directions are detected, and that a transition made while clear is held is lost for good. The bench also shows the absence of a false event after reset while the input is held high.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic setFlag;
    logic clearFlag;
  } hpdStrobes_t;
endpackage

// File: rtl/hpd_datapath.sv
module hpd_datapath
  import hpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hpdAsync,
  input  hpdStrobes_t strobes,
  output logic        syncLevel,
  output logic        edgeSeen,
  output logic        flag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          history;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= hpdAsync;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[LAST-1:0], hpdAsync};
      end
    end
  endgenerate

  assign syncLevel = syncChain[LAST];
  assign edgeSeen  = syncLevel ^ history;

  always_ff @(posedge clk) begin
    if (rst) history <= 1'b0;
    else     history <= syncLevel;
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag <= 1'b0;
    else if (strobes.clearFlag) flag <= 1'b0;
    else if (strobes.setFlag)   flag <= 1'b1;
  end
endmodule

// File: rtl/hpd_control.sv
module hpd_control
  import hpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clearCtl,
  input  logic        edgeSeen,
  output hpdStrobes_t strobes
);
  // Detection stays off until the chain and history hold real input values
  localparam int PRIME_LEN = SYNC_STAGES + 1;
  localparam int CW = $clog2(PRIME_LEN + 1);

  logic [CW-1:0] primeCnt;
  logic          armed;

  assign armed = (primeCnt == CW'(PRIME_LEN));

  always_ff @(posedge clk) begin
    if (rst)         primeCnt <= '0;
    else if (!armed) primeCnt <= primeCnt + 1'b1;
  end

  always_comb begin
    strobes.clearFlag = clearCtl;
    strobes.setFlag   = armed && edgeSeen && !clearCtl;
  end
endmodule

// File: rtl/hpd_change_irq.sv
module hpd_change_irq
  import hpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hpdAsync,
  input  logic digOutSel,
  input  logic irqEnable,
  input  logic pinOutEnable,
  input  logic clearCtl,
  output logic hpdLevel,
  output logic changePending,
  output logic tdetN,
  output logic tdetDrive,
  output logic gpioN,
  output logic gpioDrive
);
  hpdStrobes_t strobes;
  logic        edgeSeen;

  hpd_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .hpdAsync(hpdAsync), .strobes(strobes),
    .syncLevel(hpdLevel), .edgeSeen(edgeSeen), .flag(changePending)
  );

  hpd_control #(.SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rst(rst), .clearCtl(clearCtl), .edgeSeen(edgeSeen),
    .strobes(strobes)
  );

  assign tdetDrive = changePending && digOutSel;
  assign tdetN     = !tdetDrive;
  assign gpioDrive = changePending && irqEnable && pinOutEnable;
  assign gpioN     = !gpioDrive;
endmodule

// File: rtl/hpd_change_irq_chk.sv
module hpd_change_irq_chk (
  input logic clk,
  input logic rst,
  input logic digOutSel,
  input logic irqEnable,
  input logic pinOutEnable,
  input logic clearCtl,
  input logic changePending,
  input logic tdetN,
  input logic tdetDrive,
  input logic gpioN,
  input logic gpioDrive
);
  // R4
  tdet_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !digOutSel |-> (tdetN && !tdetDrive));
  // R5
  gpio_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(irqEnable && pinOutEnable) |-> (gpioN && !gpioDrive));
  // R6
  clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clearCtl |=> !changePending);
  // R6
  no_set_in_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(changePending) |-> !$past(clearCtl));
  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (changePending && !clearCtl) |=> changePending);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !changePending);
endmodule

bind hpd_change_irq hpd_change_irq_chk chk_i (
  .clk(clk), .rst(rst), .digOutSel(digOutSel), .irqEnable(irqEnable),
  .pinOutEnable(pinOutEnable), .clearCtl(clearCtl),
  .changePending(changePending), .tdetN(tdetN), .tdetDrive(tdetDrive),
  .gpioN(gpioN), .gpioDrive(gpioDrive)
);

// File: tb/hpd_change_irq_tb_top.sv
module hpd_change_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpdAsync = 1'b1;
  logic digOutSel = 1'b1;
  logic irqEnable = 1'b0;
  logic pinOutEnable = 1'b0;
  logic clearCtl = 1'b0;
  logic hpdLevel, changePending, tdetN, tdetDrive, gpioN, gpioDrive;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_change_irq dut_i (
    .clk(clk), .rst(rst), .hpdAsync(hpdAsync), .digOutSel(digOutSel),
    .irqEnable(irqEnable), .pinOutEnable(pinOutEnable), .clearCtl(clearCtl),
    .hpdLevel(hpdLevel), .changePending(changePending), .tdetN(tdetN),
    .tdetDrive(tdetDrive), .gpioN(gpioN), .gpioDrive(gpioDrive)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOutputs(input string req, input bit tdetOn, input bit gpioOn);
    #1;
    check(req, "tdetN", tdetN, !tdetOn);
    check(req, "tdetDrive", tdetDrive, tdetOn);
    check(req, "gpioN", gpioN, !gpioOn);
    check(req, "gpioDrive", gpioDrive, gpioOn);
  endtask

  task automatic clearFlag();
    clearCtl = 1'b1;
    cycles(1);
    check("R6", "flag cleared one edge after clear bit", changePending, 0);
    clearCtl = 1'b0;
    cycles(1);
  endtask

  // R8: reset with input held high; no false event after release
  task automatic testReset();
    cycles(3);
    check("R8", "flag in reset", changePending, 0);
    checkOutputs("R8", 0, 0);
    rst = 1'b0;
    cycles(8);
    check("R8", "no spurious event after reset", changePending, 0);
    check("R1", "level after reset", hpdLevel, 1);
    checkOutputs("R8", 0, 0);
  endtask

  // R3 and R1: falling transition latency
  task automatic testFalling();
    hpdAsync = 1'b0;
    cycles(1);
    check("R1", "level unchanged after one edge", hpdLevel, 1);
    cycles(1);
    check("R1", "level after two edges", hpdLevel, 0);
    check("R3", "flag not yet set", changePending, 0);
    cycles(1);
    check("R3", "flag set on falling transition", changePending, 1);
    checkOutputs("R4", 1, 0);
  endtask

  // R6: transitions made while clear is held are lost
  task automatic testClearHold();
    clearCtl = 1'b1;
    cycles(1);
    check("R6", "flag cleared", changePending, 0);
    hpdAsync = 1'b1;
    cycles(5);
    check("R6", "flag held clear during transition", changePending, 0);
    check("R1", "level follows while clearing", hpdLevel, 1);
    clearCtl = 1'b0;
    cycles(5);
    check("R6", "old transition not reported", changePending, 0);
    checkOutputs("R6", 0, 0);
    hpdAsync = 1'b0;
    cycles(3);
    check("R6", "detection resumed", changePending, 1);
  endtask

  // R2: rising transition latency
  task automatic testRising();
    clearFlag();
    hpdAsync = 1'b1;
    cycles(2);
    check("R2", "flag not yet set", changePending, 0);
    cycles(1);
    check("R2", "flag set on rising transition", changePending, 1);
  endtask

  // R7: sticky flag across further transitions
  task automatic testSticky();
    hpdAsync = 1'b0;
    cycles(4);
    check("R7", "flag stays set", changePending, 1);
    check("R1", "level while pending", hpdLevel, 0);
    hpdAsync = 1'b1;
    cycles(10);
    check("R7", "flag still set", changePending, 1);
  endtask

  // R4 and R5: output gating with flag set
  task automatic testGating();
    for (int m = 0; m < 8; m++) begin
      digOutSel    = m[0];
      irqEnable    = m[1];
      pinOutEnable = m[2];
      checkOutputs(m[2:1] == 2'b11 ? "R5" : "R4", m[0], m[2:1] == 2'b11);
    end
    clearFlag();
    checkOutputs("R5", 0, 0);
    digOutSel = 1'b1;
  endtask

  // R8: reset while a change is pending
  task automatic testMidReset();
    hpdAsync = 1'b0;
    cycles(3);
    check("R8", "flag set before reset", changePending, 1);
    rst = 1'b1;
    cycles(1);
    check("R8", "flag cleared by reset", changePending, 0);
    checkOutputs("R8", 0, 0);
    rst = 1'b0;
    cycles(8);
    check("R8", "no event after reset with low input", changePending, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        testReset();
        testFalling();
        testClearHold();
        testRising();
        testSticky();
        testGating();
        testMidReset();
      end
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule